// File: doc/BRIEF.md
# Cascadable 4-bit ALU Bit Slice

This block is one slice of a microprogrammed datapath. Each cycle a 9-bit microinstruction steers two operands from a sixteen-word register file, the working register Q, the external data input or zero into an eight-function arithmetic and logic unit. The instruction also says where the result goes: the register file, Q, both of them with a shift up or down, or nowhere. The slice's output bus shows either the result or the first register-file read port. Several slices sit side by side to build wider words. The carry output feeds the next slice's carry input, and the active-low generate and propagate outputs feed external lookahead logic.

The instruction is split into three 3-bit fields. Bits 2..0 pick the operand pair, bits 5..3 pick the function and bits 8..6 pick the destination. The register file is read at address A and address B and is written only at address B, at the rising clock edge that ends the cycle. The operands used in a cycle are the contents from before that edge, so a register can be read, modified and written back in one cycle. Each end of the register-file path and of the Q path has a shift line. Each line is modelled as an input, an output and a drive enable, so a neighbouring slice can supply the bit that enters and take the bit that leaves. The all-zero flag has its own drive enable, which models an open-collector pin that is wired together across slices.

Top module: `bitslice_alu`

## Requirements
- R1: After reset is released, Q and all sixteen register-file words read as zero.
- R2: instr[2:0] selects the operands (R, S) as follows: 0=(A,Q), 1=(A,B), 2=(0,Q), 3=(0,B), 4=(0,A), 5=(D,A), 6=(D,Q), 7=(D,0). A and B are the register-file words at a_addr and b_addr, and D is d_in.
- R3: instr[5:3] selects the function: 0=R+S+cin, 1=S+~R+cin, 2=R+~S+cin, 3=R|S, 4=R&S, 5=~R&S, 6=R^S, 7=~(R^S). The 4-bit result is F.
- R4: instr[8:6] codes 0..3 behave as follows: 0 loads Q with F; 1 loads nothing; 2 loads the register word at b_addr with F; 3 does the same as 2. y_out shows the A port word for code 2 and F for every other code.
- R5: Operands are the register-file contents from before the clock edge that ends the cycle. A write goes only to b_addr and is visible on the next cycle.
- R6: Codes 4 and 5 shift down. The register word at b_addr receives {ram_msb_in, F[3:1]}. ram_lsb_out carries F[0] and q_lsb_out carries Q[0], and both have their enables high. Code 4 also loads Q with {q_msb_in, Q[3:1]}.
- R7: Codes 6 and 7 shift up. The register word at b_addr receives {F[2:0], ram_lsb_in}. ram_msb_out carries F[3] and q_msb_out carries Q[3], and both have their enables high. Code 6 also loads Q with {Q[2:0], q_lsb_in}.
- R8: Q changes only for destination codes 0, 4 and 6.
- R9: cout is the carry out of bit 3. ovf is the XOR of the carries into and out of bit 3. f_msb is F[3]. f_zero is high exactly when F is zero, and f_zero_oe is its inverse.
- R10: For the arithmetic functions (0..2), with operands R' and S' after any inversion, g=R'&S' and p=R'|S'. prop_n is ~(p3&p2&p1&p0) and gen_n is ~(g3|p3g2|p3p2g1|p3p2p1g0). For the logic functions (3..7), cout=0, ovf=0, gen_n=1 and prop_n=1.
- R11: For destination codes 0..3 all four shift-line enables are low and all four shift outputs are 0. The down enables and the up enables are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of Q and the register file |
| instr | input | 9 | Microinstruction: [2:0] source, [5:3] function, [8:6] destination |
| d_in | input | 4 | External data operand |
| a_addr | input | 4 | Register-file read address, port A |
| b_addr | input | 4 | Register-file read address, port B, and write address |
| cin | input | 1 | Carry into the least significant bit |
| ram_lsb_in | input | 1 | Bit entering register-file path LSB on an up shift |
| ram_msb_in | input | 1 | Bit entering register-file path MSB on a down shift |
| q_lsb_in | input | 1 | Bit entering Q LSB on an up shift |
| q_msb_in | input | 1 | Bit entering Q MSB on a down shift |
| y_out | output | 4 | Result or port A word |
| cout | output | 1 | Carry out of the MSB |
| gen_n | output | 1 | Active-low carry generate |
| prop_n | output | 1 | Active-low carry propagate |
| ovf | output | 1 | Signed overflow |
| f_zero | output | 1 | Result is all zero |
| f_zero_oe | output | 1 | Drive enable for the open-collector zero line (pull low) |
| f_msb | output | 1 | Result sign bit |
| ram_lsb_out | output | 1 | Bit leaving register-file path LSB |
| ram_lsb_oe | output | 1 | Enable for ram_lsb_out |
| ram_msb_out | output | 1 | Bit leaving register-file path MSB |
| ram_msb_oe | output | 1 | Enable for ram_msb_out |
| q_lsb_out | output | 1 | Bit leaving Q LSB |
| q_lsb_oe | output | 1 | Enable for q_lsb_out |
| q_msb_out | output | 1 | Bit leaving Q MSB |
| q_msb_oe | output | 1 | Enable for q_msb_out |

## Verification
The bench targets the read-modify-write of one register in a single cycle. If the write leaked into the operand, that cycle's output would show the incremented value, or the result would be counted twice. It walks both subtraction orders with known operands. Swapped operand inversion gives 0xE where 0x2 is expected, and it also flips the carry and generate outputs. The four shift codes are driven with distinct fill bits, and the shifted-out bits, the enables and the stored words are all checked. Because of this, a fill taken from the wrong end, an enable on the wrong side, or a Q that moves on codes 5 or 7 changes a value that is read back. Overflow is exercised in both directions (0x3+0x5 and 0x8+0x8), and a design that takes overflow from the carry out alone gets the first case wrong.

// File: rtl/slice_pkg.sv
package slice_pkg;

    typedef enum logic [2:0] {
        SRC_AQ = 3'd0,
        SRC_AB = 3'd1,
        SRC_ZQ = 3'd2,
        SRC_ZB = 3'd3,
        SRC_ZA = 3'd4,
        SRC_DA = 3'd5,
        SRC_DQ = 3'd6,
        SRC_DZ = 3'd7
    } src_e;

    typedef enum logic [2:0] {
        FN_ADD   = 3'd0,
        FN_SMINR = 3'd1,
        FN_RMINS = 3'd2,
        FN_OR    = 3'd3,
        FN_AND   = 3'd4,
        FN_NRAND = 3'd5,
        FN_XOR   = 3'd6,
        FN_XNOR  = 3'd7
    } func_e;

    typedef enum logic [2:0] {
        DST_QREG  = 3'd0,
        DST_NONE  = 3'd1,
        DST_RAMA  = 3'd2,
        DST_RAMF  = 3'd3,
        DST_DNRQ  = 3'd4,
        DST_DNR   = 3'd5,
        DST_UPRQ  = 3'd6,
        DST_UPR   = 3'd7
    } dest_e;

    localparam int SRC_LSB  = 0;
    localparam int FUNC_LSB = 3;
    localparam int DEST_LSB = 6;

endpackage

// File: rtl/slice_regfile.sv
module slice_regfile #(
    parameter int WIDTH  = 4,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic              we,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  a_data,
    output logic [WIDTH-1:0]  b_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WIDTH-1:0] mem [DEPTH];

    // Operands are read from the pre-edge contents; the write commits at the edge.
    assign a_data = mem[a_addr];
    assign b_data = mem[b_addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[b_addr] <= wdata;
        end
    end

    // R5: a word written at b_addr is what port A returns next cycle at that address
    assert_write_visible_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && we) |=> ((a_addr != $past(b_addr)) || (a_data == $past(wdata))));

endmodule

// File: rtl/slice_operand_sel.sv
module slice_operand_sel
    import slice_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  src_e             src,
    input  logic [WIDTH-1:0] a_data,
    input  logic [WIDTH-1:0] b_data,
    input  logic [WIDTH-1:0] q_data,
    input  logic [WIDTH-1:0] d_data,
    output logic [WIDTH-1:0] r_op,
    output logic [WIDTH-1:0] s_op
);
    always_comb begin
        r_op = '0;
        s_op = '0;
        unique case (src)
            SRC_AQ: begin r_op = a_data; s_op = q_data; end
            SRC_AB: begin r_op = a_data; s_op = b_data; end
            SRC_ZQ: begin r_op = '0;     s_op = q_data; end
            SRC_ZB: begin r_op = '0;     s_op = b_data; end
            SRC_ZA: begin r_op = '0;     s_op = a_data; end
            SRC_DA: begin r_op = d_data; s_op = a_data; end
            SRC_DQ: begin r_op = d_data; s_op = q_data; end
            SRC_DZ: begin r_op = d_data; s_op = '0;     end
        endcase
    end

endmodule

// File: rtl/slice_alu.sv
module slice_alu
    import slice_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  func_e            func,
    input  logic [WIDTH-1:0] r_op,
    input  logic [WIDTH-1:0] s_op,
    input  logic             cin,
    output logic [WIDTH-1:0] f,
    output logic             cout,
    output logic             ovf,
    output logic             gen_n,
    output logic             prop_n
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] r_adj;
    logic [WIDTH-1:0] s_adj;
    logic [WIDTH:0]   full_sum;
    logic [MSB:0]     low_sum;
    logic [WIDTH-1:0] g_bit;
    logic [WIDTH-1:0] p_bit;
    logic             g_grp;
    logic             p_grp;
    logic             is_arith;

    assign is_arith = (func == FN_ADD) || (func == FN_SMINR) || (func == FN_RMINS);

    // Operand inversion for the two subtract orderings.
    always_comb begin
        r_adj = r_op;
        s_adj = s_op;
        if (func == FN_SMINR) r_adj = ~r_op;
        if (func == FN_RMINS) s_adj = ~s_op;
    end

    assign full_sum = {1'b0, r_adj} + {1'b0, s_adj} + {{WIDTH{1'b0}}, cin};
    assign low_sum  = {1'b0, r_adj[MSB-1:0]} + {1'b0, s_adj[MSB-1:0]} + {{MSB{1'b0}}, cin};

    assign g_bit = r_adj & s_adj;
    assign p_bit = r_adj | s_adj;

    // Group generate/propagate, folded from the LSB upward.
    always_comb begin
        g_grp = 1'b0;
        p_grp = 1'b1;
        for (int i = 0; i < WIDTH; i++) begin
            g_grp = g_bit[i] | (p_bit[i] & g_grp);
            p_grp = p_grp & p_bit[i];
        end
    end

    always_comb begin
        f = '0;
        unique case (func)
            FN_ADD, FN_SMINR, FN_RMINS: f = full_sum[WIDTH-1:0];
            FN_OR:    f = r_op | s_op;
            FN_AND:   f = r_op & s_op;
            FN_NRAND: f = ~r_op & s_op;
            FN_XOR:   f = r_op ^ s_op;
            FN_XNOR:  f = ~(r_op ^ s_op);
        endcase
    end

    assign cout   = is_arith & full_sum[WIDTH];
    assign ovf    = is_arith & (full_sum[WIDTH] ^ low_sum[MSB]);
    assign gen_n  = ~(is_arith & g_grp);
    assign prop_n = ~(is_arith & p_grp);

endmodule

// File: rtl/slice_dest.sv
module slice_dest
    import slice_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  dest_e            dest,
    input  logic [WIDTH-1:0] f,
    input  logic [WIDTH-1:0] q_data,
    input  logic [WIDTH-1:0] a_data,
    input  logic             ram_lsb_in,
    input  logic             ram_msb_in,
    input  logic             q_lsb_in,
    input  logic             q_msb_in,
    output logic             ram_we,
    output logic [WIDTH-1:0] ram_wdata,
    output logic             q_we,
    output logic [WIDTH-1:0] q_next,
    output logic [WIDTH-1:0] y,
    output logic             ram_lsb_out,
    output logic             ram_lsb_oe,
    output logic             ram_msb_out,
    output logic             ram_msb_oe,
    output logic             q_lsb_out,
    output logic             q_lsb_oe,
    output logic             q_msb_out,
    output logic             q_msb_oe
);
    localparam int MSB = WIDTH - 1;

    logic             shift_dn;
    logic             shift_up;
    logic [WIDTH-1:0] f_dn;
    logic [WIDTH-1:0] f_up;
    logic [WIDTH-1:0] q_dn;
    logic [WIDTH-1:0] q_up;

    assign f_dn = {ram_msb_in, f[MSB:1]};
    assign f_up = {f[MSB-1:0], ram_lsb_in};
    assign q_dn = {q_msb_in, q_data[MSB:1]};
    assign q_up = {q_data[MSB-1:0], q_lsb_in};

    always_comb begin
        ram_we    = 1'b0;
        ram_wdata = f;
        q_we      = 1'b0;
        q_next    = f;
        y         = f;
        shift_dn  = 1'b0;
        shift_up  = 1'b0;
        unique case (dest)
            DST_QREG: begin q_we = 1'b1; q_next = f; end
            DST_NONE: begin end
            DST_RAMA: begin ram_we = 1'b1; y = a_data; end
            DST_RAMF: begin ram_we = 1'b1; end
            DST_DNRQ: begin
                ram_we = 1'b1; ram_wdata = f_dn;
                q_we   = 1'b1; q_next    = q_dn;
                shift_dn = 1'b1;
            end
            DST_DNR: begin
                ram_we = 1'b1; ram_wdata = f_dn;
                shift_dn = 1'b1;
            end
            DST_UPRQ: begin
                ram_we = 1'b1; ram_wdata = f_up;
                q_we   = 1'b1; q_next    = q_up;
                shift_up = 1'b1;
            end
            DST_UPR: begin
                ram_we = 1'b1; ram_wdata = f_up;
                shift_up = 1'b1;
            end
        endcase
    end

    assign ram_lsb_oe  = shift_dn;
    assign q_lsb_oe    = shift_dn;
    assign ram_msb_oe  = shift_up;
    assign q_msb_oe    = shift_up;
    assign ram_lsb_out = shift_dn & f[0];
    assign q_lsb_out   = shift_dn & q_data[0];
    assign ram_msb_out = shift_up & f[MSB];
    assign q_msb_out   = shift_up & q_data[MSB];

endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
    import slice_pkg::*;
#(
    parameter int WIDTH  = 4,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [8:0]        instr,
    input  logic [WIDTH-1:0]  d_in,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic              cin,
    input  logic              ram_lsb_in,
    input  logic              ram_msb_in,
    input  logic              q_lsb_in,
    input  logic              q_msb_in,
    output logic [WIDTH-1:0]  y_out,
    output logic              cout,
    output logic              gen_n,
    output logic              prop_n,
    output logic              ovf,
    output logic              f_zero,
    output logic              f_zero_oe,
    output logic              f_msb,
    output logic              ram_lsb_out,
    output logic              ram_lsb_oe,
    output logic              ram_msb_out,
    output logic              ram_msb_oe,
    output logic              q_lsb_out,
    output logic              q_lsb_oe,
    output logic              q_msb_out,
    output logic              q_msb_oe
);
    localparam int MSB = WIDTH - 1;

    src_e  src;
    func_e func;
    dest_e dest;

    assign src  = src_e'(instr[SRC_LSB +: 3]);
    assign func = func_e'(instr[FUNC_LSB +: 3]);
    assign dest = dest_e'(instr[DEST_LSB +: 3]);

    logic [WIDTH-1:0] a_data;
    logic [WIDTH-1:0] b_data;
    logic [WIDTH-1:0] q_reg;
    logic [WIDTH-1:0] q_next;
    logic             q_we;
    logic [WIDTH-1:0] r_op;
    logic [WIDTH-1:0] s_op;
    logic [WIDTH-1:0] f;
    logic             ram_we;
    logic [WIDTH-1:0] ram_wdata;

    slice_regfile #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_addr (a_addr),
        .b_addr (b_addr),
        .we     (ram_we),
        .wdata  (ram_wdata),
        .a_data (a_data),
        .b_data (b_data)
    );

    slice_operand_sel #(.WIDTH(WIDTH)) u_sel (
        .src    (src),
        .a_data (a_data),
        .b_data (b_data),
        .q_data (q_reg),
        .d_data (d_in),
        .r_op   (r_op),
        .s_op   (s_op)
    );

    slice_alu #(.WIDTH(WIDTH)) u_alu (
        .func   (func),
        .r_op   (r_op),
        .s_op   (s_op),
        .cin    (cin),
        .f      (f),
        .cout   (cout),
        .ovf    (ovf),
        .gen_n  (gen_n),
        .prop_n (prop_n)
    );

    slice_dest #(.WIDTH(WIDTH)) u_dst (
        .dest        (dest),
        .f           (f),
        .q_data      (q_reg),
        .a_data      (a_data),
        .ram_lsb_in  (ram_lsb_in),
        .ram_msb_in  (ram_msb_in),
        .q_lsb_in    (q_lsb_in),
        .q_msb_in    (q_msb_in),
        .ram_we      (ram_we),
        .ram_wdata   (ram_wdata),
        .q_we        (q_we),
        .q_next      (q_next),
        .y           (y_out),
        .ram_lsb_out (ram_lsb_out),
        .ram_lsb_oe  (ram_lsb_oe),
        .ram_msb_out (ram_msb_out),
        .ram_msb_oe  (ram_msb_oe),
        .q_lsb_out   (q_lsb_out),
        .q_lsb_oe    (q_lsb_oe),
        .q_msb_out   (q_msb_out),
        .q_msb_oe    (q_msb_oe)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_reg <= '0;
        end else if (q_we) begin
            q_reg <= q_next;
        end
    end

    assign f_zero    = (f == '0);
    assign f_zero_oe = |f;
    assign f_msb     = f[MSB];

    // R8: Q holds for every destination other than the Q-loading codes
    assert_q_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !(dest inside {DST_QREG, DST_DNRQ, DST_UPRQ})) |=> $stable(q_reg));

    // R6: a down shift of Q takes its new MSB from the shift-in line
    assert_q_down_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && dest == DST_DNRQ) |=> (q_reg[MSB] == $past(q_msb_in)));

    // R7: an up shift of Q takes its new LSB from the shift-in line
    assert_q_up_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && dest == DST_UPRQ) |=> (q_reg[0] == $past(q_lsb_in)));

    // R11: shift lines idle for plain destinations, and never both directions
    assert_shift_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (dest inside {DST_QREG, DST_NONE, DST_RAMA, DST_RAMF}) |->
            !(ram_lsb_oe || ram_msb_oe || q_lsb_oe || q_msb_oe));
    assert_shift_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_lsb_oe, ram_msb_oe}) && $onehot0({q_lsb_oe, q_msb_oe}));

    // R10: logic functions leave carry and lookahead outputs inactive
    assert_logic_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (func inside {FN_OR, FN_AND, FN_NRAND, FN_XOR, FN_XNOR}) |->
            (!cout && !ovf && gen_n && prop_n));

    // R9: a zero flag with Y showing F means the visible result is zero
    assert_zero_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (f_zero && dest != DST_RAMA) |-> (y_out == '0));

    // R4: code 2 routes the port A word to Y
    assert_y_porta_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dest == DST_RAMA) |-> (y_out == a_data));

endmodule

// File: tb/tb_bitslice_alu.sv
`timescale 1ns/1ps
module tb_bitslice_alu;

    logic       clk;
    logic       rst_n;
    logic [8:0] instr;
    logic [3:0] d_in, a_addr, b_addr;
    logic       cin, ram_lsb_in, ram_msb_in, q_lsb_in, q_msb_in;
    logic [3:0] y_out;
    logic       cout, gen_n, prop_n, ovf, f_zero, f_zero_oe, f_msb;
    logic       ram_lsb_out, ram_lsb_oe, ram_msb_out, ram_msb_oe;
    logic       q_lsb_out, q_lsb_oe, q_msb_out, q_msb_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    bitslice_alu dut (
        .clk(clk), .rst_n(rst_n), .instr(instr), .d_in(d_in),
        .a_addr(a_addr), .b_addr(b_addr), .cin(cin),
        .ram_lsb_in(ram_lsb_in), .ram_msb_in(ram_msb_in),
        .q_lsb_in(q_lsb_in), .q_msb_in(q_msb_in),
        .y_out(y_out), .cout(cout), .gen_n(gen_n), .prop_n(prop_n),
        .ovf(ovf), .f_zero(f_zero), .f_zero_oe(f_zero_oe), .f_msb(f_msb),
        .ram_lsb_out(ram_lsb_out), .ram_lsb_oe(ram_lsb_oe),
        .ram_msb_out(ram_msb_out), .ram_msb_oe(ram_msb_oe),
        .q_lsb_out(q_lsb_out), .q_lsb_oe(q_lsb_oe),
        .q_msb_out(q_msb_out), .q_msb_oe(q_msb_oe)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    // {instr, d, a, b, cin, y, {cout,ovf,f_zero,f_msb}, {gen_n,prop_n}}
    // State while walking: r1=3 r2=5 r3=F r4=8 r5=7 r6=A r7=1, Q=6.
    localparam logic [31:0] VECS [0:13] = '{
        {3'd1,3'd0,3'd1, 4'h0,4'h1,4'h2, 1'b0, 4'h8, 4'b0101, 2'b11},
        {3'd1,3'd0,3'd0, 4'h0,4'h1,4'h0, 1'b1, 4'hA, 4'b0101, 2'b11},
        {3'd1,3'd0,3'd3, 4'h0,4'h0,4'h3, 1'b1, 4'h0, 4'b1010, 2'b10},
        {3'd1,3'd1,3'd1, 4'h0,4'h2,4'h1, 1'b1, 4'hE, 4'b0001, 2'b11},
        {3'd1,3'd2,3'd1, 4'h0,4'h2,4'h1, 1'b1, 4'h2, 4'b1000, 2'b01},
        {3'd1,3'd0,3'd1, 4'h0,4'h4,4'h4, 1'b0, 4'h0, 4'b1110, 2'b01},
        {3'd1,3'd3,3'd5, 4'h5,4'h6,4'h0, 1'b0, 4'hF, 4'b0001, 2'b11},
        {3'd1,3'd4,3'd6, 4'hC,4'h0,4'h0, 1'b0, 4'h4, 4'b0000, 2'b11},
        {3'd1,3'd5,3'd1, 4'h0,4'h2,4'h3, 1'b0, 4'hA, 4'b0001, 2'b11},
        {3'd1,3'd6,3'd0, 4'h0,4'h6,4'h0, 1'b0, 4'hC, 4'b0001, 2'b11},
        {3'd1,3'd7,3'd1, 4'h0,4'h5,4'h5, 1'b0, 4'hF, 4'b0001, 2'b11},
        {3'd1,3'd6,3'd1, 4'h0,4'h3,4'h3, 1'b0, 4'h0, 4'b0010, 2'b11},
        {3'd1,3'd0,3'd2, 4'h0,4'h0,4'h0, 1'b0, 4'h6, 4'b0000, 2'b11},
        {3'd1,3'd0,3'd7, 4'hF,4'h0,4'h0, 1'b1, 4'h0, 4'b1010, 2'b10}
    };

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // sh = {ram_lsb_in, ram_msb_in, q_lsb_in, q_msb_in}
    task automatic step(input logic [8:0] ins, input logic [3:0] d, input logic [3:0] a,
                        input logic [3:0] b, input logic c, input logic [3:0] sh);
        @(negedge clk);
        instr = ins; d_in = d; a_addr = a; b_addr = b; cin = c;
        {ram_lsb_in, ram_msb_in, q_lsb_in, q_msb_in} = sh;
        #1;
    endtask

    task automatic rd_reg(input logic [3:0] addr, input logic [3:0] exp, input string tag);
        step({3'd1,3'd3,3'd4}, 4'h0, addr, 4'h0, 1'b0, 4'h0);
        chk(tag, {4'h0, y_out}, {4'h0, exp});
    endtask

    task automatic rd_q(input logic [3:0] exp, input string tag);
        step({3'd1,3'd3,3'd2}, 4'h0, 4'h0, 4'h0, 1'b0, 4'h0);
        chk(tag, {4'h0, y_out}, {4'h0, exp});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [3:0] pre [8];
        pre = '{4'h0, 4'h3, 4'h5, 4'hF, 4'h8, 4'h7, 4'hA, 4'h1};
        rst_n = 1'b0;
        instr = {3'd1,3'd3,3'd1};
        d_in = '0; a_addr = '0; b_addr = '0; cin = 1'b0;
        {ram_lsb_in, ram_msb_in, q_lsb_in, q_msb_in} = 4'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int i = 0; i < 16; i++) begin
            step({3'd1,3'd3,3'd1}, 4'h0, 4'(i), 4'(i), 1'b0, 4'h0);
            chk("R1 reg reads zero", {4'h0, y_out}, 8'h00);
        end
        rd_q(4'h0, "R1 Q reads zero");

        // Preload registers through D (dest 3, OR, D|0) and Q (dest 0)
        for (int i = 1; i < 8; i++) begin
            step({3'd3,3'd3,3'd7}, pre[i], 4'h0, 4'(i), 1'b0, 4'h0);
            chk("R4 dest3 Y=F", {4'h0, y_out}, {4'h0, pre[i]});
        end
        step({3'd0,3'd3,3'd7}, 4'h6, 4'h0, 4'h0, 1'b0, 4'h0);
        chk("R4 dest0 Y=F", {4'h0, y_out}, 8'h06);

        // Vector walk: sources, functions, status (no-load destination)
        for (int v = 0; v < 14; v++) begin
            logic [31:0] e;
            e = VECS[v];
            step(e[31:23], e[22:19], e[18:15], e[14:11], e[10], 4'h0);
            chk("R2/R3 Y result", {4'h0, y_out}, {4'h0, e[9:6]});
            chk("R9 cout/ovf/zero/msb", {4'h0, cout, ovf, f_zero, f_msb}, {4'h0, e[5:2]});
            chk("R10 gen_n/prop_n", {6'h0, gen_n, prop_n}, {6'h0, e[1:0]});
            chk("R9 zero enable", {7'h0, f_zero_oe}, {7'h0, ~e[3]});
            chk("R11 shift lines idle",
                {ram_lsb_oe, ram_msb_oe, q_lsb_oe, q_msb_oe,
                 ram_lsb_out, ram_msb_out, q_lsb_out, q_msb_out}, 8'h00);
        end

        // R5: increment r1 in place (old value used, result stored at B only)
        step({3'd3,3'd0,3'd3}, 4'h0, 4'h1, 4'h1, 1'b1, 4'h0);
        chk("R5 rmw uses old value", {4'h0, y_out}, 8'h04);
        rd_reg(4'h1, 4'h4, "R5 rmw stored");
        rd_reg(4'h2, 4'h5, "R5 other word untouched");

        // R4: dest 2 shows port A while writing F at B
        step({3'd2,3'd3,3'd7}, 4'h9, 4'h6, 4'h7, 1'b0, 4'h0);
        chk("R4 dest2 Y=A", {4'h0, y_out}, 8'h0A);
        chk("R11 dest2 lines idle", {4'h0, ram_lsb_oe, ram_msb_oe, q_lsb_oe, q_msb_oe}, 8'h00);
        rd_reg(4'h7, 4'h9, "R4 dest2 stored F");
        rd_q(4'h6, "R8 Q unchanged by dest2");

        // R4: dest 0 loads Q, RAM untouched
        step({3'd0,3'd3,3'd7}, 4'h3, 4'h0, 4'h5, 1'b0, 4'h0);
        chk("R4 dest0 Y=F", {4'h0, y_out}, 8'h03);
        rd_reg(4'h5, 4'h7, "R4 dest0 RAM untouched");
        rd_q(4'h3, "R4 dest0 Q loaded");

        // R6: dest 4, F=7, ram_msb_in=1, q_msb_in=0, Q=3
        step({3'd4,3'd3,3'd3}, 4'h0, 4'h0, 4'h5, 1'b0, 4'b0100);
        chk("R6 dest4 Y=F", {4'h0, y_out}, 8'h07);
        chk("R6 dest4 lines",
            {ram_lsb_oe, ram_msb_oe, q_lsb_oe, q_msb_oe,
             ram_lsb_out, ram_msb_out, q_lsb_out, q_msb_out}, 8'b1010_1010);
        rd_reg(4'h5, 4'hB, "R6 dest4 RAM shifted");
        rd_q(4'h1, "R6 dest4 Q shifted");

        // R6: dest 5, F=4, ram_msb_in=0, Q must hold at 1
        step({3'd5,3'd3,3'd3}, 4'h0, 4'h0, 4'h1, 1'b0, 4'b0001);
        chk("R6 dest5 lines",
            {ram_lsb_oe, ram_msb_oe, q_lsb_oe, q_msb_oe,
             ram_lsb_out, ram_msb_out, q_lsb_out, q_msb_out}, 8'b1010_0010);
        rd_reg(4'h1, 4'h2, "R6 dest5 RAM shifted");
        rd_q(4'h1, "R8 dest5 Q holds");

        // R7: dest 6, F=8, ram_lsb_in=1, q_lsb_in=1, Q=1
        step({3'd6,3'd3,3'd3}, 4'h0, 4'h0, 4'h4, 1'b0, 4'b1010);
        chk("R7 dest6 lines",
            {ram_lsb_oe, ram_msb_oe, q_lsb_oe, q_msb_oe,
             ram_lsb_out, ram_msb_out, q_lsb_out, q_msb_out}, 8'b0101_0100);
        rd_reg(4'h4, 4'h1, "R7 dest6 RAM shifted");
        rd_q(4'h3, "R7 dest6 Q shifted");

        // R7: dest 7, F=F, ram_lsb_in=0, Q must hold at 3
        step({3'd7,3'd3,3'd3}, 4'h0, 4'h0, 4'h3, 1'b0, 4'b0010);
        chk("R7 dest7 lines",
            {ram_lsb_oe, ram_msb_oe, q_lsb_oe, q_msb_oe,
             ram_lsb_out, ram_msb_out, q_lsb_out, q_msb_out}, 8'b0101_0100);
        rd_reg(4'h3, 4'hE, "R7 dest7 RAM shifted");
        rd_q(4'h3, "R8 dest7 Q holds");

        finish_run();
    end

endmodule